// File: doc/BRIEF.md
# Memory LCD Serial Frame Streamer

This block feeds a serial memory-type monochrome panel over a write-only SPI link made of chip select, serial clock and data. A requester pulses one of three request inputs: a full-screen refresh, a panel wipe, or a hold command that keeps the panel showing its stored image. For a refresh, the block fetches pixel bytes from an external framebuffer RAM through a synchronous read port. It wraps the pixel bytes in a write opcode, per-line row numbers, per-line padding and a closing pad byte.

Each transfer occupies its own chip-select window. After every refresh, the block starts a second window by itself and sends the hold command in it. `busy` covers the whole job. `done` pulses once as each window closes.

Top module: `mlcd_streamer`

## Requirements
- R1: While reset is held and in the first cycle after it, `lcd_cs`, `lcd_sclk`, `lcd_mosi`, `busy`, `done` and `fb_rd` are all low.
- R2: Every byte is sent least significant bit first. `lcd_sclk` idles low. The data bit is stable while `lcd_sclk` is high and changes only while it is low. Within a byte, rising edges are exactly CLK_DIV clock cycles apart.
- R3: A refresh sends, in one chip-select window, the opcode 0x01. It then sends LINES line records in ascending order. Each record is the row number counted from 1, then BPL pixel bytes, then a 0x00 pad. One 0x00 trailer byte ends the window.
- R4: Pixel byte c of line l (both counted from 0) is read from framebuffer address l*BPL + c. The read strobe comes one cycle before the data is taken, and the address is always below LINES*BPL.
- R5: A wipe request sends exactly the bytes 0x04, 0x00 in one chip-select window.
- R6: A hold request sends exactly the bytes 0x00, 0x00 in one chip-select window.
- R7: Every refresh window is followed, without a new request, by a separate hold window carrying 0x00, 0x00. Chip select stays low for at least CLK_DIV cycles between the two windows.
- R8: Chip select is active high. It is high for at least CLK_DIV cycles before the first rising edge of `lcd_sclk` and for at least CLK_DIV cycles after the last falling edge. `lcd_sclk` never toggles while chip select is low.
- R9: `busy` rises in the cycle after a request is taken and stays high until the last window of the job has closed. Requests that arrive while `busy` is high start no window and add no byte.
- R10: `done` is a single-cycle pulse. It is high exactly in the cycle in which chip select has just fallen, once for every window.
- R11: When several requests are high in the same idle cycle, refresh wins over wipe and wipe wins over hold. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_frame | input | 1 | Full-screen refresh request |
| req_clear | input | 1 | Panel wipe request |
| req_hold | input | 1 | Hold-command request |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse as each chip-select window ends |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_addr | output | $clog2(LINES*BPL) | Framebuffer byte address |
| fb_rdata | input | 8 | Framebuffer read data, valid one cycle after fb_rd |
| lcd_cs | output | 1 | Panel chip select, active high |
| lcd_sclk | output | 1 | Serial clock |
| lcd_mosi | output | 1 | Serial data |

## Verification
Two of the block's functions can meet in one cycle: the acceptance of a new request, and the choice among requests raised together. The same applies to a request raised while a refresh, or the hold window that follows it, is still running. The bench raises all three requests in one idle cycle and also wipe with hold. It also pulses wipe and hold in the middle of a refresh. Each outcome is judged by the byte stream captured from the serial pins, which must match only the winning job's windows, with no extra window and no extra done pulse.

// File: rtl/mlcd_pkg.sv
package mlcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_ISSUE, ST_LOAD, ST_WAIT, ST_TAIL, ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        JOB_FRAME, JOB_CLEAR, JOB_HOLD
    } job_t;

    typedef enum logic [2:0] {
        IT_CMD, IT_ROW, IT_DATA, IT_PAD, IT_TRAIL, IT_ARG
    } item_t;

    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_CLEAR = 8'h04;
    localparam logic [7:0] OP_HOLD  = 8'h00;
    localparam logic [7:0] PAD_BYTE = 8'h00;

    function automatic logic [7:0] opcode_of(input job_t j);
        case (j)
            JOB_FRAME: return OP_WRITE;
            JOB_CLEAR: return OP_CLEAR;
            default:   return OP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/mlcd_req_arb.sv
module mlcd_req_arb
    import mlcd_pkg::*;
(
    input  logic req_frame,
    input  logic req_clear,
    input  logic req_hold,
    output logic any_req,
    output job_t pick
);
    always_comb begin
        any_req = req_frame | req_clear | req_hold;
        if (req_frame)      pick = JOB_FRAME;
        else if (req_clear) pick = JOB_CLEAR;
        else                pick = JOB_HOLD;
    end
endmodule

// File: rtl/mlcd_bit_engine.sv
module mlcd_bit_engine #(
    parameter int CLK_DIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] din,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done
);
    localparam int HALF = CLK_DIV / 2;
    localparam int DW   = $clog2(HALF + 1);

    logic          act;
    logic          hi;
    logic [DW-1:0] div;
    logic [2:0]    bitc;
    logic [7:0]    sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= 1'b0;
            hi        <= 1'b0;
            div       <= '0;
            bitc      <= '0;
            sh        <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!act) begin
                if (load) begin
                    act  <= 1'b1;
                    hi   <= 1'b0;
                    div  <= '0;
                    bitc <= '0;
                    sh   <= din;
                end
            end else if (div == DW'(HALF - 1)) begin
                div <= '0;
                if (!hi) begin
                    hi <= 1'b1;
                end else begin
                    hi <= 1'b0;
                    if (bitc == 3'd7) begin
                        act       <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        sh   <= sh >> 1;
                        bitc <= bitc + 3'd1;
                    end
                end
            end else begin
                div <= div + DW'(1);
            end
        end
    end

    assign sclk = hi;
    assign mosi = act & sh[0];
endmodule

// File: rtl/mlcd_frame_seq.sv
module mlcd_frame_seq
    import mlcd_pkg::*;
#(
    parameter int LINES   = 96,
    parameter int BPL     = 12,
    parameter int CLK_DIV = 16,
    parameter int AW      = $clog2(LINES * BPL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  job_t          start_job,
    input  logic          byte_done,
    input  logic [7:0]    fb_rdata,
    output logic          load,
    output logic [7:0]    load_byte,
    output logic          fb_rd,
    output logic [AW-1:0] fb_addr,
    output logic          cs,
    output logic          busy,
    output logic          done
);
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int CW = (BPL > 1) ? $clog2(BPL) : 1;
    localparam int TW = $clog2(CLK_DIV + 1);

    seq_state_t    st;
    job_t          job;
    item_t         item;
    logic [LW-1:0] line_q;
    logic [CW-1:0] col_q;
    logic [TW-1:0] tmr;
    logic          tmr_end;
    logic [7:0]    item_byte;

    assign tmr_end = (tmr == TW'(CLK_DIV - 1));
    assign busy    = (st != ST_IDLE);
    assign fb_rd   = (st == ST_ISSUE) && (item == IT_DATA);
    assign fb_addr = AW'(line_q) * AW'(BPL) + AW'(col_q);

    always_comb begin
        case (item)
            IT_CMD:  item_byte = opcode_of(job);
            IT_ROW:  item_byte = 8'(line_q) + 8'd1;
            default: item_byte = PAD_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            job       <= JOB_HOLD;
            item      <= IT_CMD;
            line_q    <= '0;
            col_q     <= '0;
            tmr       <= '0;
            cs        <= 1'b0;
            done      <= 1'b0;
            load      <= 1'b0;
            load_byte <= '0;
        end else begin
            done <= 1'b0;
            load <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    job  <= start_job;
                    item <= IT_CMD;
                    cs   <= 1'b1;
                    tmr  <= '0;
                    st   <= ST_LEAD;
                end
                ST_LEAD: begin
                    if (tmr_end) st <= ST_ISSUE;
                    else         tmr <= tmr + TW'(1);
                end
                ST_ISSUE: begin
                    if (item == IT_DATA) begin
                        st <= ST_LOAD;
                    end else begin
                        load      <= 1'b1;
                        load_byte <= item_byte;
                        st        <= ST_WAIT;
                    end
                end
                ST_LOAD: begin
                    load      <= 1'b1;
                    load_byte <= fb_rdata;
                    st        <= ST_WAIT;
                end
                ST_WAIT: if (byte_done) begin
                    tmr <= '0;
                    st  <= ST_ISSUE;
                    case (item)
                        IT_CMD: begin
                            if (job == JOB_FRAME) begin
                                item   <= IT_ROW;
                                line_q <= '0;
                            end else begin
                                item <= IT_ARG;
                            end
                        end
                        IT_ROW: begin
                            item  <= IT_DATA;
                            col_q <= '0;
                        end
                        IT_DATA: begin
                            if (col_q == CW'(BPL - 1)) item <= IT_PAD;
                            else                       col_q <= col_q + CW'(1);
                        end
                        IT_PAD: begin
                            if (line_q == LW'(LINES - 1)) begin
                                item <= IT_TRAIL;
                            end else begin
                                line_q <= line_q + LW'(1);
                                item   <= IT_ROW;
                            end
                        end
                        default: st <= ST_TAIL;
                    endcase
                end
                ST_TAIL: begin
                    if (tmr_end) begin
                        cs   <= 1'b0;
                        done <= 1'b1;
                        tmr  <= '0;
                        if (job == JOB_FRAME) begin
                            job <= JOB_HOLD;
                            st  <= ST_GAP;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                ST_GAP: begin
                    if (tmr_end) begin
                        cs   <= 1'b1;
                        item <= IT_CMD;
                        tmr  <= '0;
                        st   <= ST_LEAD;
                    end else begin
                        tmr <= tmr + TW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mlcd_streamer.sv
module mlcd_streamer
    import mlcd_pkg::*;
#(
    parameter int LINES   = 96,
    parameter int BPL     = 12,
    parameter int CLK_DIV = 16,
    localparam int AW     = $clog2(LINES * BPL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_frame,
    input  logic          req_clear,
    input  logic          req_hold,
    output logic          busy,
    output logic          done,
    output logic          fb_rd,
    output logic [AW-1:0] fb_addr,
    input  logic [7:0]    fb_rdata,
    output logic          lcd_cs,
    output logic          lcd_sclk,
    output logic          lcd_mosi
);
    logic       any_req;
    job_t       pick;
    logic       load;
    logic [7:0] load_byte;
    logic       byte_done;
    logic       seq_busy;

    mlcd_req_arb u_arb (
        .req_frame (req_frame),
        .req_clear (req_clear),
        .req_hold  (req_hold),
        .any_req   (any_req),
        .pick      (pick)
    );

    mlcd_frame_seq #(.LINES(LINES), .BPL(BPL), .CLK_DIV(CLK_DIV), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (any_req),
        .start_job (pick),
        .byte_done (byte_done),
        .fb_rdata  (fb_rdata),
        .load      (load),
        .load_byte (load_byte),
        .fb_rd     (fb_rd),
        .fb_addr   (fb_addr),
        .cs        (lcd_cs),
        .busy      (seq_busy),
        .done      (done)
    );

    mlcd_bit_engine #(.CLK_DIV(CLK_DIV)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .din       (load_byte),
        .sclk      (lcd_sclk),
        .mosi      (lcd_mosi),
        .byte_done (byte_done)
    );

    assign busy = seq_busy;
endmodule

// File: rtl/mlcd_streamer_chk.sv
module mlcd_streamer_chk #(
    parameter int LINES = 96,
    parameter int BPL   = 12,
    parameter int AW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          fb_rd,
    input logic [AW-1:0] fb_addr,
    input logic          lcd_cs,
    input logic          lcd_sclk,
    input logic          lcd_mosi
);
    localparam int DEPTH = LINES * BPL;

    AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
        !lcd_cs |-> !lcd_sclk); // R8
    AST_CS_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_cs) |-> !lcd_sclk); // R8
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lcd_sclk && $past(lcd_sclk)) |-> $stable(lcd_mosi)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_AT_CS_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(lcd_cs)); // R10
    AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        lcd_cs |-> busy); // R9
    AST_FB_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> (int'(fb_addr) < DEPTH)); // R4
    AST_FB_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        fb_rd |-> lcd_cs); // R3
endmodule

bind mlcd_streamer mlcd_streamer_chk #(.LINES(LINES), .BPL(BPL), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .fb_rd    (fb_rd),
    .fb_addr  (fb_addr),
    .lcd_cs   (lcd_cs),
    .lcd_sclk (lcd_sclk),
    .lcd_mosi (lcd_mosi)
);

// File: tb/sim_mlcd_streamer.sv
module sim_mlcd_streamer;
    localparam int LINES   = 4;
    localparam int BPL     = 12;
    localparam int CLK_DIV = 4;
    localparam int DEPTH   = LINES * BPL;
    localparam int AW      = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_frame = 1'b0, req_clear = 1'b0, req_hold = 1'b0;
    logic          busy, done, fb_rd, lcd_cs, lcd_sclk, lcd_mosi;
    logic [AW-1:0] fb_addr;
    logic [7:0]    fb_rdata = '0;

    int    n_chk = 0, n_err = 0, n_done = 0, exp_windows = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    mlcd_streamer #(.LINES(LINES), .BPL(BPL), .CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst(rst), .req_frame(req_frame), .req_clear(req_clear),
        .req_hold(req_hold), .busy(busy), .done(done), .fb_rd(fb_rd),
        .fb_addr(fb_addr), .fb_rdata(fb_rdata), .lcd_cs(lcd_cs),
        .lcd_sclk(lcd_sclk), .lcd_mosi(lcd_mosi)
    );

    function automatic int pat(input int i);
        return (i * 37 + 5) % 256;
    endfunction

    always @(posedge clk) if (fb_rd) fb_rdata <= 8'(pat(int'(fb_addr)));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic push_short(input int op, input string t);
        push(op, t); push(0, t); push(-1, t);
        exp_windows++;
    endtask

    task automatic push_frame(input string ctag);
        push(1, ctag);
        for (int l = 0; l < LINES; l++) begin
            push(l + 1, "R3");
            for (int c = 0; c < BPL; c++) push(pat(l * BPL + c), "R4");
            push(0, "R3");
        end
        push(0, "R3");
        push(-1, "R3");
        exp_windows++;
        push_short(0, "R7");
    endtask

    // scoreboard monitor
    bit       cs_p = 0, sclk_p = 0, first_pend = 0;
    int       lead = 0, tail = 0, low_cnt = 0, since_rise = 0, bitn = 0;
    logic [7:0] cur;

    task automatic pop_cmp(input int act);
        int e; string t;
        if (exp_q.size() == 0) begin
            check(0, "R9", act, -2);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(act == e, t, act, e);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            since_rise++;
            if (lcd_cs && !cs_p) begin
                check(low_cnt >= CLK_DIV, "R7", low_cnt, CLK_DIV);
                lead = 0; first_pend = 1; bitn = 0;
            end else if (lcd_cs && first_pend && !(lcd_sclk && !sclk_p)) begin
                lead++;
            end
            if (lcd_sclk && !sclk_p) begin
                if (first_pend) begin
                    check(lead >= CLK_DIV, "R8", lead, CLK_DIV);
                    first_pend = 0;
                end
                if (bitn > 0) check(since_rise == CLK_DIV, "R2", since_rise, CLK_DIV);
                since_rise = 0;
                cur[bitn] = lcd_mosi;
                bitn++;
                if (bitn == 8) begin
                    pop_cmp(int'(cur));
                    bitn = 0;
                end
            end
            if (!lcd_sclk && sclk_p) tail = 0;
            else if (lcd_cs) tail++;
            if (!lcd_cs && cs_p) begin
                check(done == 1'b1, "R10", done, 1);
                check(tail >= CLK_DIV, "R8", tail, CLK_DIV);
                check(bitn == 0, "R2", bitn, 0);
                pop_cmp(-1);
                low_cnt = 1;
            end else if (!lcd_cs) begin
                low_cnt++;
                if (done) check(0, "R10", done, 0);
            end
            if (done) n_done++;
            cs_p = lcd_cs;
            sclk_p = lcd_sclk;
        end
    end

    task automatic request(input bit f, input bit c, input bit h);
        @(negedge clk);
        req_frame = f; req_clear = c; req_hold = h;
        @(negedge clk);
        req_frame = 0; req_clear = 0; req_hold = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "R9", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        low_cnt = 1000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check({lcd_cs, lcd_sclk, lcd_mosi, busy, done, fb_rd} == 6'b0, "R1",
              {lcd_cs, lcd_sclk, lcd_mosi, busy, done, fb_rd}, 0);
        rst = 0;
        @(negedge clk);
        check({lcd_cs, lcd_sclk, lcd_mosi, busy, done, fb_rd} == 6'b0, "R1",
              {lcd_cs, lcd_sclk, lcd_mosi, busy, done, fb_rd}, 0);

        push_short(0, "R6");
        request(0, 0, 1);
        check(busy == 1'b1, "R9", busy, 1);
        wait_idle();

        push_short(4, "R5");
        request(0, 1, 0);
        check(busy == 1'b1, "R9", busy, 1);
        wait_idle();

        push_frame("R3");
        request(1, 0, 0);
        check(busy == 1'b1, "R9", busy, 1);
        repeat (300) @(negedge clk);
        request(0, 1, 0);
        check(busy == 1'b1, "R9", busy, 1);
        repeat (200) @(negedge clk);
        request(0, 0, 1);
        @(negedge clk);
        while (u0.lcd_cs || !busy) @(negedge clk);
        request(0, 1, 1);
        wait_idle();
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);

        push_frame("R11");
        request(1, 1, 1);
        wait_idle();

        push_short(4, "R11");
        request(0, 1, 1);
        wait_idle();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R11", exp_q.size(), 0);
        check(n_done == exp_windows, "R10", n_done, exp_windows);
        check(busy == 1'b0, "R9", busy, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule